// File: doc/BRIEF.md
# Multiplexed-Bus Host Register Slave

This block lets a host processor reach a small internal register array over a shared 32-bit address/data bus. The host selects the block with an active-low chip select and marks the address phase with an active-low address strobe. Read and write intent arrive on two separate active-low request lines. The block captures the word address and, on a write, takes the data word one clock later. After a fixed access latency it completes the cycle with an active-low ready. On a read it drives the bus when ready is asserted, through a registered output enable.

The host may end a cycle at any clock. It does so by raising chip select or by releasing both request lines. The block then releases the bus and ready on the next edge. Two restart rules apply. After a completed cycle, a new cycle may begin on the first edge after the edge that saw the end. After a cycle aborted before ready, one idle clock must pass first. The shared bus is split into an input word, an output word and an output enable, and a pad ring outside the block joins them.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, rdy_n is 1, bus_oe is 0, bus_out is 0 and all 16 registers read as zero.
- R2: A cycle starts only on an edge, in the idle state, where cs_n and as_n are both sampled 0. The word address is taken from bus_in on that edge. as_n low with cs_n high starts nothing.
- R3: A write takes its data from bus_in on the first edge after the start edge. rdy_n falls on the second edge after the start edge, and the register is updated on that same edge.
- R4: On a read, rdy_n falls and bus_oe rises on the second edge after the start edge, with bus_out carrying the addressed register.
- R5: Word addresses 16 and above read as zero. Writes to them change no register.
- R6: While the host keeps the cycle open, rdy_n stays 0, and bus_oe stays at its completion value (1 for a read, 0 for a write). The write is committed once, and later bus changes do not alter it.
- R7: An edge that samples cs_n = 1, or rd_n = wr_n = 1, ends an open cycle. After that edge rdy_n is 1, bus_oe is 0 and bus_out is 0.
- R8: If a cycle ends before rdy_n fell, nothing is written. A start on the first edge after the aborting edge is ignored. A start on the second edge is accepted.
- R9: After a completed cycle, a start on the first edge after the terminating edge is accepted.
- R10: bus_oe is 1 only while rdy_n is 0. It rises only on the edge where rdy_n falls, so it is never 1 in the clock after a start edge.
- R11: With rd_n and wr_n both 0 at completion, the cycle is performed as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read request, active low |
| wr_n | input | 1 | Write request, active low |
| bus_in | input | 32 | Word sampled from the shared bus |
| bus_out | output | 32 | Word to drive onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| rdy_n | output | 1 | Ready, active low |

## Verification
The checker watches, on every clock, the handshake invariants. These are: the enable occurs only under ready, the bus is zero while released, and the release follows a termination. It also checks that enable and ready change together, that each write strobe is a single pulse, and that ready falls only in a selected cycle. Other behaviour needs the bench's scenarios, because it depends on what the host did several clocks earlier. This covers the exact two-clock latency, returned data against a model, out-of-range aliasing, and the different restart spacing after an abort and after a completion.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DONE = 2'd2,
        ST_GAP  = 2'd3
    } hbs_state_e;
endpackage

// File: rtl/hbs_regfile.sv
module hbs_regfile #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (we && (widx == IW'(i))) begin
                mem_q[i] <= wdata;
            end
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 16,
    parameter int LAT   = 2,
    localparam int IW   = $clog2(WORDS),
    localparam int CW   = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          as_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [IW-1:0] rf_idx,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          rdy_n
);
    typedef struct packed {
        hbs_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          rdy_n;
        logic          oe;
        logic [DW-1:0] dout;
    } ctrl_t;

    ctrl_t q, d;

    logic start, finish, in_range;

    always_comb begin
        start    = !cs_n && !as_n;
        finish   = cs_n || (rd_n && wr_n);
        in_range = (q.addr < AW'(WORDS));
        d        = q;
        rf_we    = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_ACC;
                    d.cnt   = '0;
                    d.addr  = AW'(bus_in);
                end
            end
            ST_ACC: begin
                if (finish) begin
                    d.state = ST_GAP;
                end else begin
                    if (q.cnt == '0) begin
                        d.wdata = bus_in;
                    end
                    if (q.cnt == CW'(LAT - 1)) begin
                        d.state = ST_DONE;
                        d.rdy_n = 1'b0;
                        if (!wr_n) begin
                            rf_we = in_range;
                        end else begin
                            d.oe   = 1'b1;
                            d.dout = in_range ? rf_rdata : '0;
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_DONE: begin
                if (finish) begin
                    d.state = ST_IDLE;
                    d.rdy_n = 1'b1;
                    d.oe    = 1'b0;
                    d.dout  = '0;
                end
            end
            ST_GAP: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.addr  <= '0;
            q.wdata <= '0;
            q.rdy_n <= 1'b1;
            q.oe    <= 1'b0;
            q.dout  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rf_idx   = q.addr[IW-1:0];
    assign rf_wdata = q.wdata;
    assign bus_out  = q.dout;
    assign bus_oe   = q.oe;
    assign rdy_n    = q.rdy_n;
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 16,
    parameter int LAT   = 2,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          as_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          rdy_n
);
    logic          wr_en;
    logic [IW-1:0] rf_idx;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata;

    hbs_ctrl #(
        .AW(AW), .DW(DW), .WORDS(WORDS), .LAT(LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .as_n     (as_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .bus_in   (bus_in),
        .rf_rdata (rf_rdata),
        .rf_we    (wr_en),
        .rf_idx   (rf_idx),
        .rf_wdata (rf_wdata),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .rdy_n    (rdy_n)
    );

    hbs_regfile #(
        .DW(DW), .WORDS(WORDS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .widx  (rf_idx),
        .wdata (rf_wdata),
        .ridx  (rf_idx),
        .rdata (rf_rdata)
    );
endmodule

// File: rtl/hbs_chk.sv
module hbs_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe,
    input logic          rdy_n,
    input logic          we
);
    // R10
    oe_under_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !rdy_n);

    // R7
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R7
    release_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && (cs_n || (rd_n && wr_n))) |=> (rdy_n && !bus_oe));

    // R10
    oe_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $fell(rdy_n));

    // R6
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R2
    ready_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> !$past(cs_n));
endmodule

bind hostbus_slave hbs_chk #(.DW(DW)) u_hbs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .rdy_n   (rdy_n),
    .we      (wr_en)
);

// File: tb/tb_hostbus_slave.sv
`timescale 1ns/1ps
module tb_hostbus_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, as_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;
    logic        bus_oe, rdy_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mdl [16];

    always #2 clk = ~clk;

    hostbus_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rdy_n(rdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] a);
        return (a < 32'd16) ? mdl[a[3:0]] : 32'd0;
    endfunction

    // Full cycle; starts at a negedge, ends at the negedge after the terminating edge.
    task automatic do_cycle(input bit wr, input logic [31:0] a, input logic [31:0] dat,
                            input int hold, input bit end_by_cs, input bit both);
        cs_n = 0; as_n = 0; bus_in = a; rd_n = wr && !both; wr_n = !wr;
        @(negedge clk);
        as_n = 1; bus_in = wr ? dat : $urandom;
        chk(rdy_n && !bus_oe, "R10 no drive after start", {30'd0, bus_oe, rdy_n}, 32'd1);
        @(negedge clk);
        chk(rdy_n == 1'b1, "R3 latency", {31'd0, rdy_n}, 32'd1);
        if (wr) bus_in = ~dat;
        @(negedge clk);
        chk(rdy_n == 1'b0, "R3/R4 ready after two clocks", {31'd0, rdy_n}, 32'd0);
        if (wr) begin
            chk(!bus_oe, both ? "R11 write priority" : "R3 write no drive", {31'd0, bus_oe}, 32'd0);
            if (a < 32'd16) mdl[a[3:0]] = dat;
        end else begin
            chk(bus_oe && bus_out == exp_rd(a), a < 32'd16 ? "R4 read data" : "R5 out of range read",
                bus_out, exp_rd(a));
        end
        for (int i = 0; i < hold; i++) begin
            bus_in = $urandom;
            @(negedge clk);
            chk(!rdy_n && bus_oe == !wr, "R6 held open", {30'd0, bus_oe, rdy_n}, {30'd0, !wr, 1'b0});
        end
        if (end_by_cs) cs_n = 1;
        rd_n = 1; wr_n = 1;
        @(negedge clk);
        chk(rdy_n && !bus_oe && bus_out == 0, "R7 release", bus_out, 32'd0);
        cs_n = 1;
        // R9: the caller may start the next cycle at once
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rdy_n && !bus_oe && bus_out == 0, "R1 reset outputs", bus_out, 32'd0);
        for (int i = 0; i < 16; i++) do_cycle(0, i, 0, 0, 1, 0);   // R1 registers zero

        // R2: strobe without select starts nothing
        as_n = 0; bus_in = 3; rd_n = 0;
        repeat (4) begin
            @(negedge clk);
            chk(rdy_n && !bus_oe, "R2 no start without select", {31'd0, rdy_n}, 32'd1);
        end
        as_n = 1; rd_n = 1;
        @(negedge clk);

        // R5: aliased address write must not touch word 0
        do_cycle(1, 0, 32'h1111_2222, 0, 1, 0);
        do_cycle(1, 32'd16, 32'hDEAD_BEEF, 1, 1, 0);
        do_cycle(0, 0, 0, 0, 1, 0);
        do_cycle(0, 32'h8000_0003, 0, 0, 0, 0);

        // R11: both requests low writes
        do_cycle(1, 5, 32'hA5A5_0005, 0, 1, 1);
        do_cycle(0, 5, 0, 2, 1, 0);

        // R8: aborts, via select and via request lines
        for (int k = 0; k < 2; k++) begin
            cs_n = 0; as_n = 0; bus_in = 9; rd_n = 1; wr_n = 0;
            @(negedge clk);
            as_n = 1; bus_in = 32'h7777_0000 + k;
            if (k == 0) cs_n = 1; else wr_n = 1;
            @(negedge clk);
            chk(rdy_n && !bus_oe, "R8 abort no ready", {31'd0, rdy_n}, 32'd1);
            cs_n = 0; as_n = 0; bus_in = 9; rd_n = 0; wr_n = 1;
            @(negedge clk);                                 // first edge: ignored
            @(negedge clk);                                 // second edge: accepted
            as_n = 1;
            chk(rdy_n == 1'b1, "R8 restart spacing", {31'd0, rdy_n}, 32'd1);
            @(negedge clk);
            chk(rdy_n == 1'b1, "R8 restart spacing", {31'd0, rdy_n}, 32'd1);
            @(negedge clk);
            chk(!rdy_n && bus_out == mdl[9], "R8 no commit on abort", bus_out, mdl[9]);
            cs_n = 1; rd_n = 1;
            @(negedge clk);
        end

        // Random back-to-back traffic (R9 by immediate restarts)
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            a = ($urandom % 8 == 0) ? 32'd16 + ($urandom % 64) : ($urandom % 16);
            do_cycle($urandom % 2, a, $urandom, $urandom % 4, $urandom % 2, $urandom % 5 == 0);
        end
        for (int i = 0; i < 16; i++) do_cycle(0, i, 0, 0, 1, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule